// File: doc/BRIEF.md
# PCI Host Reset Control Unit

This unit produces the active-low reset that a PCI host drives onto the bus. It also produces the reset that a PCI controller applies to its own register set. Two sources start a reset. The first is the synchronous chip power-on reset. The second is a software reset, started and stopped through a reset bit in a control word. A cycle counter keeps a software reset on for a minimum time (1 ms at the bus clock by default), even when software clears the bit sooner. All sequencing runs on the bus clock, and the internal reset is released on an edge of that clock.

While a software reset is in force, software can still reach the control word. Every other controller register is fenced off: writes to those registers are dropped and reads of them return zero. At the start of a software reset a one-cycle clear pulse wipes the registers that are marked as resettable. The retained registers keep their contents and are cleared only by power-on reset. A manual reset input is accepted and ignored. When the unit is not the bus host, the bus reset output stays high.

Top module: `pci_host_rst_unit`

## Requirements
- R1: While `rst` is high and `host_mode` is 1, `bus_rst_n` is 0 and `ctl_rst` is 1. On the first clock edge where `rst` is low and no software reset is active, `bus_rst_n` goes to 1, `ctl_rst` goes to 0 and `acc_en` goes to 1.
- R2: A write to address 0 that sets bit 0 of the control word, while that bit is 0, starts a software reset. One cycle after the write edge, `bus_rst_n` is 0 (in host mode) and `ctl_rst` is 1, and both change on the same edge.
- R3: A software reset keeps `ctl_rst` high, and `bus_rst_n` low in host mode, for at least MIN_CYC cycles, even if bit 0 is cleared on the very next cycle. The outputs return to their idle values MIN_CYC+1 cycles after the setting write edge.
- R4: While bit 0 stays 1, the reset stays asserted past MIN_CYC. A write that clears bit 0 after the minimum time has passed releases `bus_rst_n` and `ctl_rst` one cycle after that write edge.
- R5: While `acc_en` is 0, a write to a bank register at addresses 1..NREG is dropped, and a read of one returns 0. The control word at address 0 stays readable and writable.
- R6: While bit 0 is 1, a control-word write changes only bit 0. The bits [DW-1:1] keep their value until a later write made while bit 0 is 0. A write made while bit 0 is 0 loads the whole word.
- R7: The `mrst` input has no effect on any output, on the control word or on the bank registers.
- R8: One cycle after the start of a software reset, `clr_rsv` pulses high for exactly one cycle. The bank registers whose RST_MASK bit is 1 (addresses 1 and 3 by default) read 0 afterwards. The others (addresses 2 and 4) keep their value. `hold_ret` is high while the software reset lasts.
- R9: With `host_mode` 0, `bus_rst_n` stays 1 through both power-on and software reset, and `ctl_rst` still follows the software reset.
- R10: Power-on reset clears the whole control word, the bank and the minimum-hold counter. A software reset in progress is therefore ended on the first edge after `rst` falls.
- R11: A read returns its data on `reg_rdata` one cycle after the edge that samples `reg_rd`. Address 0 returns the control word, and addresses above NREG return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all sequencing runs on it |
| rst | input | 1 | Synchronous active-high power-on reset |
| host_mode | input | 1 | 1 when this controller is the bus host |
| mrst | input | 1 | Manual reset request, ignored |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register address: 0 control word, 1..NREG bank |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, one cycle after the read |
| bus_rst_n | output | 1 | Active-low bus reset |
| ctl_rst | output | 1 | Internal controller reset, active high |
| acc_en | output | 1 | High when bank registers may be accessed |
| clr_rsv | output | 1 | One-cycle clear of resettable registers |
| hold_ret | output | 1 | High while retained registers hold through a software reset |

## Verification
The properties assume that `host_mode` is changed only while no software reset is running or while `rst` is high. The stimulus follows this: it switches host mode only around idle periods and power-on pulses. The properties also assume that `reg_wr` and `reg_rd` are never high in the same cycle, and that MIN_CYC is larger than two, so that a software reset cannot end inside the window right after power-on. The stimulus issues one access per cycle and runs with MIN_CYC set to 20.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CTL  = 2'd1,
    ACC_BANK = 2'd2,
    ACC_VOID = 2'd3
  } acc_kind_e;

  localparam int unsigned SWRST_BIT = 0;
endpackage

// File: rtl/hrc_ctl_reg.sv
module hrc_ctl_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_q,
  output logic          swbit,
  output logic          set_evt
);
  import hrc_pkg::*;

  assign swbit   = ctl_q[SWRST_BIT];
  assign set_evt = wr & ~ctl_q[SWRST_BIT] & wdata[SWRST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr) begin
      if (ctl_q[SWRST_BIT]) begin
        ctl_q[SWRST_BIT] <= wdata[SWRST_BIT];
      end else begin
        ctl_q <= wdata;
      end
    end
  end
endmodule

// File: rtl/hrc_min_timer.sv
module hrc_min_timer #(
  parameter int unsigned MIN_CYC = 33333
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(MIN_CYC);

  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= LOAD;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/hrc_reg_bank.sv
module hrc_reg_bank #(
  parameter int unsigned       DW       = 16,
  parameter int unsigned       NREG     = 4,
  parameter logic [NREG-1:0]   RST_MASK = 4'b0101,
  localparam int unsigned      IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_en,
  input  logic                     clr,
  input  logic                     wr,
  input  logic [IW-1:0]            idx,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rd_word,
  output logic [NREG-1:0][DW-1:0]  bank_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr & acc_en & (idx == IW'(g));
    if (RST_MASK[g]) begin : g_clr
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          bank_q[g] <= '0;
        end else if (hit) begin
          bank_q[g] <= wdata;
        end
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (rst) begin
          bank_q[g] <= '0;
        end else if (hit) begin
          bank_q[g] <= wdata;
        end
      end
    end
  end

  assign rd_word = acc_en ? bank_q[idx] : '0;
endmodule

// File: rtl/pci_host_rst_unit.sv
module pci_host_rst_unit #(
  parameter int unsigned     DW       = 16,
  parameter int unsigned     NREG     = 4,
  parameter int unsigned     AW       = 3,
  parameter int unsigned     MIN_CYC  = 33333,
  parameter logic [NREG-1:0] RST_MASK = 4'b0101
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_mode,
  input  logic          mrst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          bus_rst_n,
  output logic          ctl_rst,
  output logic          acc_en,
  output logic          clr_rsv,
  output logic          hold_ret
);
  import hrc_pkg::*;

  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic                    unused_mrst;
  acc_kind_e               kind;
  logic [IW-1:0]           idx;
  logic [DW-1:0]           ctl_q;
  logic [DW-1:0]           bank_word;
  logic [NREG-1:0][DW-1:0] bank_q;
  logic                    swbit;
  logic                    set_evt;
  logic                    busy;
  logic                    sw_active;
  logic                    sw_q;

  assign unused_mrst = mrst;

  always_comb begin
    if (!reg_wr && !reg_rd) begin
      kind = ACC_NONE;
    end else if (reg_addr == '0) begin
      kind = ACC_CTL;
    end else if (reg_addr <= AW'(NREG)) begin
      kind = ACC_BANK;
    end else begin
      kind = ACC_VOID;
    end
  end

  assign idx = IW'(reg_addr - AW'(1));

  hrc_ctl_reg #(.DW(DW)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr && (kind == ACC_CTL)),
    .wdata   (reg_wdata),
    .ctl_q   (ctl_q),
    .swbit   (swbit),
    .set_evt (set_evt)
  );

  hrc_min_timer #(.MIN_CYC(MIN_CYC)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (set_evt),
    .busy  (busy)
  );

  hrc_reg_bank #(.DW(DW), .NREG(NREG), .RST_MASK(RST_MASK)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .acc_en  (acc_en),
    .clr     (clr_rsv),
    .wr      (reg_wr && (kind == ACC_BANK)),
    .idx     (idx),
    .wdata   (reg_wdata),
    .rd_word (bank_word),
    .bank_q  (bank_q)
  );

  assign sw_active = swbit | busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rst_n <= ~host_mode;
      ctl_rst   <= 1'b1;
      acc_en    <= 1'b0;
      clr_rsv   <= 1'b0;
      hold_ret  <= 1'b0;
      sw_q      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      bus_rst_n <= ~(host_mode & sw_active);
      ctl_rst   <= sw_active;
      acc_en    <= ~sw_active;
      clr_rsv   <= sw_active & ~sw_q;
      hold_ret  <= sw_active;
      sw_q      <= sw_active;
      if (reg_rd) begin
        case (kind)
          ACC_CTL:  reg_rdata <= ctl_q;
          ACC_BANK: reg_rdata <= bank_word;
          default:  reg_rdata <= '0;
        endcase
      end else begin
        reg_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/hrc_chk.sv
module hrc_chk #(
  parameter int unsigned DW      = 16,
  parameter int unsigned NREG    = 4,
  parameter int unsigned AW      = 3,
  parameter int unsigned MIN_CYC = 33333
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    host_mode,
  input logic                    reg_wr,
  input logic                    reg_rd,
  input logic [AW-1:0]           reg_addr,
  input logic [DW-1:0]           reg_rdata,
  input logic                    bus_rst_n,
  input logic                    ctl_rst,
  input logic                    acc_en,
  input logic                    clr_rsv,
  input logic [DW-1:0]           ctl_q,
  input logic [NREG-1:0][DW-1:0] bank_q
);
  localparam int unsigned RW = $clog2(MIN_CYC + 2);
  localparam logic [RW-1:0] RMAX = RW'(MIN_CYC);

  logic [RW-1:0] run;
  logic          rst_d1;
  logic          rst_d2;

  always_ff @(posedge clk) begin
    rst_d1 <= rst;
    rst_d2 <= rst_d1;
    if (rst) begin
      run <= '0;
    end else if (ctl_rst) begin
      if (run != RMAX) run <= run + 1'b1;
    end else begin
      run <= '0;
    end
  end

  p_host_por_r1: assert property (@(posedge clk) rst && host_mode |=> !bus_rst_n);

  p_pair_r2: assert property (@(posedge clk) disable iff (rst)
    host_mode |=> (!bus_rst_n == ctl_rst));

  p_min_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_rst) && !rst_d1 && !rst_d2 |-> (run >= RMAX));

  p_block_wr_r5: assert property (@(posedge clk) disable iff (rst)
    !acc_en && !clr_rsv && reg_wr && (reg_addr != '0) |=> $stable(bank_q));

  p_block_rd_r5: assert property (@(posedge clk) disable iff (rst)
    !acc_en && reg_rd && (reg_addr != '0) |=> (reg_rdata == '0));

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ctl_q[0] && reg_wr |=> $stable(ctl_q[DW-1:1]));

  p_clr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    clr_rsv |=> !clr_rsv);

  p_nonhost_r9: assert property (@(posedge clk) !host_mode |=> bus_rst_n);
endmodule

bind pci_host_rst_unit hrc_chk #(
  .DW(DW), .NREG(NREG), .AW(AW), .MIN_CYC(MIN_CYC)
) u_chk (.*);

// File: tb/pci_host_rst_unit_tb.sv
module pci_host_rst_unit_tb;
  localparam int unsigned DW = 16;
  localparam int unsigned NREG = 4;
  localparam int unsigned AW = 3;
  localparam int unsigned M = 20;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } rd_item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_mode = 1'b1;
  logic          mrst = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          bus_rst_n, ctl_rst, acc_en, clr_rsv, hold_ret;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  rd_item_t    rd_q[$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  pci_host_rst_unit #(.DW(DW), .NREG(NREG), .AW(AW), .MIN_CYC(M), .RST_MASK(4'b0101)) u_dut (
    .clk(clk), .rst(rst), .host_mode(host_mode), .mrst(mrst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_rst_n(bus_rst_n), .ctl_rst(ctl_rst),
    .acc_en(acc_en), .clr_rsv(clr_rsv), .hold_ret(hold_ret)
  );

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.tag = tag;
    rd_q.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= reg_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (rd_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", reg_rdata);
      end else begin
        rd_item_t it;
        it = rd_q.pop_front();
        check(reg_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bus_rst_n, 1'b0, "R1 bus reset in por");
    check(ctl_rst, 1'b1, "R1 ctl reset in por");
    rst = 1'b0;
    @(negedge clk);
    check(bus_rst_n, 1'b1, "R1 bus released");
    check(ctl_rst, 1'b0, "R1 ctl released");
    check(acc_en, 1'b1, "R1 access enabled");
    do_rd(0, 16'h0000, "R10 ctl zero after por");

    do_wr(1, 16'h1111); do_wr(2, 16'h2222); do_wr(3, 16'h3333); do_wr(4, 16'h4444);
    do_rd(1, 16'h1111, "R11 bank1"); do_rd(4, 16'h4444, "R11 bank4");
    do_rd(6, 16'h0000, "R11 void addr");
    do_wr(0, 16'h00A0);
    do_rd(0, 16'h00A0, "R11 ctl word");

    mrst = 1'b1;
    repeat (3) @(negedge clk);
    check(bus_rst_n, 1'b1, "R7 bus unchanged");
    check(ctl_rst, 1'b0, "R7 ctl unchanged");
    mrst = 1'b0;
    do_rd(0, 16'h00A0, "R7 ctl kept");
    do_rd(3, 16'h3333, "R7 bank kept");

    do_wr(0, 16'h00A1);
    @(negedge clk);
    check(bus_rst_n, 1'b0, "R2 bus asserted");
    check(ctl_rst, 1'b1, "R2 ctl asserted");
    check(clr_rsv, 1'b1, "R8 clear pulse");
    check(hold_ret, 1'b1, "R8 hold level");
    check(acc_en, 1'b0, "R5 access disabled");
    @(negedge clk);
    check(clr_rsv, 1'b0, "R8 pulse one cycle");
    do_wr(2, 16'hBEEF);
    do_rd(2, 16'h0000, "R5 read blocked");
    do_rd(0, 16'h00A1, "R5 ctl readable");
    repeat (M) @(negedge clk);
    check(bus_rst_n, 1'b0, "R4 held by bit");
    do_wr(0, 16'h5500);
    @(negedge clk);
    check(bus_rst_n, 1'b1, "R4 released");
    check(ctl_rst, 1'b0, "R4 ctl released");
    do_rd(0, 16'h00A0, "R6 cfg bits ignored");
    do_rd(2, 16'h2222, "R8 retained kept");
    do_rd(1, 16'h0000, "R8 resettable cleared");
    do_rd(3, 16'h0000, "R8 resettable cleared 3");
    do_rd(4, 16'h4444, "R8 retained kept 4");
    do_wr(0, 16'h5500);
    do_rd(0, 16'h5500, "R6 later write loads");

    do_wr(0, 16'h0001);
    do_wr(0, 16'h0000);
    check(bus_rst_n, 1'b0, "R3 early clear still low");
    repeat (M - 1) @(negedge clk);
    check(bus_rst_n, 1'b0, "R3 low at last min cycle");
    @(negedge clk);
    check(bus_rst_n, 1'b1, "R3 release after min");
    check(ctl_rst, 1'b0, "R3 ctl release after min");

    host_mode = 1'b0;
    do_wr(0, 16'h0001);
    @(negedge clk);
    check(bus_rst_n, 1'b1, "R9 nonhost bus high");
    check(ctl_rst, 1'b1, "R9 nonhost ctl reset");
    do_wr(0, 16'h0000);
    repeat (M + 2) @(negedge clk);
    check(ctl_rst, 1'b0, "R9 nonhost ctl released");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(bus_rst_n, 1'b1, "R9 nonhost por bus high");
    rst = 1'b0; host_mode = 1'b1;
    @(negedge clk);
    do_rd(0, 16'h0000, "R10 ctl cleared");
    do_rd(2, 16'h0000, "R10 retained cleared by por");

    do_wr(0, 16'h0001);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(bus_rst_n, 1'b1, "R10 por ends sw reset");
    check(ctl_rst, 1'b0, "R10 ctl cleared by por");
    do_rd(0, 16'h0000, "R10 bit cleared");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule